// File: doc/BRIEF.md
# Per-Thread Line Watch Unit

This block holds one address watch slot for each hardware thread of a multithreaded core. A thread first arms its slot with a virtual address. It then issues a wait request that carries the translated physical address. If no wakeup is pending for that thread, the slot stores the cache-line-aligned physical address, enters the waiting state, and the block answers in the same cycle that the thread may sleep. If a wakeup is already pending, the request consumes it and the block answers that the thread must not sleep.

Two sources can end a wait. Coherent snoops (invalidations or remote writes) are compared against every slot. Stores issued by the core's own threads carry the storing thread's index and are compared only against the other threads' slots. A slot matches when it is armed, waiting and holds the same line. Any match in a cycle clears the matched slots, sets the pending-wakeup flag of every thread at the same clock edge, and raises a one-cycle core wake pulse on the following cycle.

Top module: `thread_line_watch`

## Requirements
- R1: After reset every armed, waiting and pending-wakeup flag, every stored address and the core wake output are zero.
- R2: An arm request with a valid thread index sets that thread's armed flag, stores the given virtual address and sets the stored line address to zero.
- R3: A wait request from a thread whose pending-wakeup flag is clear drives `mwait_sleep` high in the same cycle, and at the next edge stores the physical address with its low log2(LINE_BYTES) bits forced to zero and sets the waiting flag.
- R4: A wait request from a thread whose pending-wakeup flag is set drives `mwait_sleep` low, clears that flag and leaves the waiting flag and stored line unchanged.
- R5: A snoop is compared against every slot; a slot matches when armed, waiting and its line equals the snoop address with the line offset cleared. A matched slot clears armed and waiting, and `core_wake` is high for exactly the cycle after any match.
- R6: A local store matches only slots of threads other than the index it carries; a store never affects the storing thread's own slot.
- R7: On any match, the pending-wakeup flag of every thread is set at the same edge.
- R8: Arm, wait and store requests whose thread index is at or above THREADS have no effect, and a wait request with such an index drives `mwait_sleep` low.
- R9: When a wait request and a matching snoop or store reach the same thread in one cycle, the wait applies first: the thread is answered sleep, ends the cycle not waiting, with its pending-wakeup flag set.
- R10: When an arm and a wait request target the same thread in one cycle, the arm applies first and the wait then acts on the armed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm request |
| arm_tid | input | TID_W | Thread index of the arm request |
| arm_vaddr | input | ADDR_W | Virtual address to watch |
| mwait_valid | input | 1 | Wait request |
| mwait_tid | input | TID_W | Thread index of the wait request |
| mwait_paddr | input | ADDR_W | Translated physical address of the watched location |
| mwait_sleep | output | 1 | Combinational answer: the waiting thread may sleep |
| snoop_valid | input | 1 | Coherent snoop present |
| snoop_addr | input | ADDR_W | Snoop physical address |
| store_valid | input | 1 | Local store present |
| store_tid | input | TID_W | Thread index that issued the store |
| store_addr | input | ADDR_W | Store physical address |
| thr_armed | output | THREADS | Armed flag per thread |
| thr_waiting | output | THREADS | Waiting flag per thread |
| thr_woken | output | THREADS | Pending-wakeup flag per thread |
| mon_vaddr | output | THREADS*ADDR_W | Stored virtual address per thread, thread t at bits t*ADDR_W upward |
| mon_line | output | THREADS*ADDR_W | Stored line address per thread, same packing |
| core_wake | output | 1 | One-cycle pulse after any slot matched |

## Verification
On every cycle the assertions check that a core wake pulse coincides with all pending-wakeup flags set, that a sleep answer leaves the thread waiting unless a wake happened, that a no-sleep answer consumes the thread's pending flag, that invalid indices never yield sleep, and that a waiting slot always holds a line-aligned address. Whether a store is kept away from its own thread's slot, the ordering when arm, wait and a match collide in one cycle, and the exact stored addresses are shown only by the bench's scenarios, which compare all slot state against a reference model each cycle.

// File: rtl/tlw_pkg.sv
package tlw_pkg;
   localparam int unsigned TLW_MAX_AW = 64;

   // Clears the line-offset bits of an address.
   function automatic logic [TLW_MAX_AW-1:0] tlw_align(
      input logic [TLW_MAX_AW-1:0] addr,
      input int unsigned           off_bits);
      logic [TLW_MAX_AW-1:0] keep;
      keep = ~((TLW_MAX_AW'(1) << off_bits) - TLW_MAX_AW'(1));
      return addr & keep;
   endfunction
endpackage

// File: rtl/tlw_tid_decode.sv
module tlw_tid_decode #(
   parameter int unsigned THREADS = 4,
   parameter int unsigned TID_W   = 3
) (
   input  logic               req_valid,
   input  logic [TID_W-1:0]   req_tid,
   output logic               req_ok,
   output logic [THREADS-1:0] req_sel
);
   assign req_ok = req_valid && ({1'b0, req_tid} < (TID_W+1)'(THREADS));

   for (genvar t = 0; t < THREADS; t++) begin : g_sel
      assign req_sel[t] = req_ok && (req_tid == TID_W'(t));
   end
endmodule

// File: rtl/tlw_slot.sv
module tlw_slot
   import tlw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_hit,
   input  logic [ADDR_W-1:0] arm_vaddr,
   input  logic              wait_hit,
   input  logic [ADDR_W-1:0] wait_paddr,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_line,
   input  logic              store_hit,
   input  logic [ADDR_W-1:0] store_line,
   input  logic              wake_all,
   output logic              match,
   output logic              may_sleep,
   output logic              armed,
   output logic              waiting,
   output logic              woken,
   output logic [ADDR_W-1:0] vaddr,
   output logic [ADDR_W-1:0] line
);
   logic              armed_q, waiting_q, woken_q;
   logic [ADDR_W-1:0] vaddr_q, line_q;

   logic              a_mid, w_mid, f_mid;
   logic [ADDR_W-1:0] v_mid, l_mid;

   // Arm first, then the wait request, then the match against the result.
   always_comb begin
      a_mid = armed_q;
      w_mid = waiting_q;
      f_mid = woken_q;
      v_mid = vaddr_q;
      l_mid = line_q;
      if (arm_hit) begin
         a_mid = 1'b1;
         v_mid = arm_vaddr;
         l_mid = '0;
      end
      if (wait_hit) begin
         if (!f_mid) begin
            l_mid = ADDR_W'(tlw_align(TLW_MAX_AW'(wait_paddr), OFF_W));
            w_mid = 1'b1;
         end else begin
            f_mid = 1'b0;
         end
      end
   end

   assign match = a_mid && w_mid &&
                  ((snoop_valid && (l_mid == snoop_line)) ||
                   (store_hit   && (l_mid == store_line)));

   assign may_sleep = !woken_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         waiting_q <= 1'b0;
         woken_q   <= 1'b0;
         vaddr_q   <= '0;
         line_q    <= '0;
      end else begin
         armed_q   <= a_mid && !match;
         waiting_q <= w_mid && !match;
         woken_q   <= f_mid || wake_all;
         vaddr_q   <= v_mid;
         line_q    <= l_mid;
      end
   end

   assign armed   = armed_q;
   assign waiting = waiting_q;
   assign woken   = woken_q;
   assign vaddr   = vaddr_q;
   assign line    = line_q;
endmodule

// File: rtl/tlw_wake_merge.sv
module tlw_wake_merge #(
   parameter int unsigned THREADS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [THREADS-1:0] slot_match,
   output logic               any_match,
   output logic               wake_pulse
);
   assign any_match = |slot_match;

   always_ff @(posedge clk) begin
      if (!rst_n) wake_pulse <= 1'b0;
      else        wake_pulse <= any_match;
   end
endmodule

// File: rtl/thread_line_watch.sv
module thread_line_watch
   import tlw_pkg::*;
#(
   parameter int unsigned THREADS    = 4,
   parameter int unsigned TID_W      = 3,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      arm_valid,
   input  logic [TID_W-1:0]          arm_tid,
   input  logic [ADDR_W-1:0]         arm_vaddr,
   input  logic                      mwait_valid,
   input  logic [TID_W-1:0]          mwait_tid,
   input  logic [ADDR_W-1:0]         mwait_paddr,
   output logic                      mwait_sleep,
   input  logic                      snoop_valid,
   input  logic [ADDR_W-1:0]         snoop_addr,
   input  logic                      store_valid,
   input  logic [TID_W-1:0]          store_tid,
   input  logic [ADDR_W-1:0]         store_addr,
   output logic [THREADS-1:0]        thr_armed,
   output logic [THREADS-1:0]        thr_waiting,
   output logic [THREADS-1:0]        thr_woken,
   output logic [THREADS*ADDR_W-1:0] mon_vaddr,
   output logic [THREADS*ADDR_W-1:0] mon_line,
   output logic                      core_wake
);
   localparam int unsigned OFF_W = $clog2(LINE_BYTES);

   if ((LINE_BYTES < 2) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if ((THREADS < 1) || ((1 << TID_W) < THREADS)) begin : g_bad_tid
      $error("TID_W too narrow for THREADS");
   end
   if ((ADDR_W <= OFF_W) || (ADDR_W > TLW_MAX_AW)) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   logic               arm_ok, wait_ok, store_ok;
   logic [THREADS-1:0] arm_sel, wait_sel, store_sel;
   logic [THREADS-1:0] slot_match, slot_sleep;
   logic               any_match;
   logic [ADDR_W-1:0]  snoop_line, store_line;

   assign snoop_line = ADDR_W'(tlw_align(TLW_MAX_AW'(snoop_addr), OFF_W));
   assign store_line = ADDR_W'(tlw_align(TLW_MAX_AW'(store_addr), OFF_W));

   tlw_tid_decode #(.THREADS(THREADS), .TID_W(TID_W)) u_dec_arm (
      .req_valid(arm_valid), .req_tid(arm_tid), .req_ok(arm_ok), .req_sel(arm_sel));
   tlw_tid_decode #(.THREADS(THREADS), .TID_W(TID_W)) u_dec_wait (
      .req_valid(mwait_valid), .req_tid(mwait_tid), .req_ok(wait_ok), .req_sel(wait_sel));
   tlw_tid_decode #(.THREADS(THREADS), .TID_W(TID_W)) u_dec_store (
      .req_valid(store_valid), .req_tid(store_tid), .req_ok(store_ok), .req_sel(store_sel));

   for (genvar t = 0; t < THREADS; t++) begin : g_slot
      tlw_slot #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .arm_hit     (arm_sel[t]),
         .arm_vaddr   (arm_vaddr),
         .wait_hit    (wait_sel[t]),
         .wait_paddr  (mwait_paddr),
         .snoop_valid (snoop_valid),
         .snoop_line  (snoop_line),
         .store_hit   (store_ok && !store_sel[t]),
         .store_line  (store_line),
         .wake_all    (any_match),
         .match       (slot_match[t]),
         .may_sleep   (slot_sleep[t]),
         .armed       (thr_armed[t]),
         .waiting     (thr_waiting[t]),
         .woken       (thr_woken[t]),
         .vaddr       (mon_vaddr[t*ADDR_W +: ADDR_W]),
         .line        (mon_line[t*ADDR_W +: ADDR_W])
      );
   end

   assign mwait_sleep = wait_ok && |(wait_sel & slot_sleep);

   tlw_wake_merge #(.THREADS(THREADS)) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_match (slot_match),
      .any_match  (any_match),
      .wake_pulse (core_wake)
   );
endmodule

// File: rtl/tlw_check.sv
module tlw_check #(
   parameter int unsigned THREADS = 4,
   parameter int unsigned TID_W   = 3,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned OFF_W   = 6
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      mwait_valid,
   input logic [TID_W-1:0]          mwait_tid,
   input logic                      mwait_sleep,
   input logic                      core_wake,
   input logic [THREADS-1:0]        thr_waiting,
   input logic [THREADS-1:0]        thr_woken,
   input logic [THREADS*ADDR_W-1:0] mon_line
);
   logic [THREADS-1:0] cur_sel;
   for (genvar t = 0; t < THREADS; t++) begin : g_cs
      assign cur_sel[t] = (mwait_tid == TID_W'(t));
   end

   // R7: a wake pulse always coincides with every thread holding a pending wakeup
   a_r7_wake_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
      core_wake |-> (&thr_woken));

   // R3: a sleep answer leaves the thread waiting unless a match woke it
   a_r3_sleep_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (mwait_valid && |cur_sel && mwait_sleep) |=>
         (|(thr_waiting & $past(cur_sel)) || core_wake));

   // R4: a no-sleep answer consumes the thread's pending wakeup
   a_r4_nosleep_consumes: assert property (@(posedge clk) disable iff (!rst_n)
      (mwait_valid && |cur_sel && !mwait_sleep) |=>
         (!(|(thr_woken & $past(cur_sel))) || core_wake));

   // R8: an out-of-range index never yields a sleep answer
   a_r8_bad_tid_awake: assert property (@(posedge clk) disable iff (!rst_n)
      (mwait_valid && !(|cur_sel)) |-> !mwait_sleep);

   for (genvar t = 0; t < THREADS; t++) begin : g_al
      // R3: a waiting slot holds a line-aligned address
      a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
         thr_waiting[t] |-> (mon_line[t*ADDR_W +: OFF_W] == '0));
   end
endmodule

bind thread_line_watch tlw_check #(
   .THREADS(THREADS), .TID_W(TID_W), .ADDR_W(ADDR_W), .OFF_W($clog2(LINE_BYTES))
) u_tlw_check (
   .clk(clk), .rst_n(rst_n), .mwait_valid(mwait_valid), .mwait_tid(mwait_tid),
   .mwait_sleep(mwait_sleep), .core_wake(core_wake), .thr_waiting(thr_waiting),
   .thr_woken(thr_woken), .mon_line(mon_line)
);

// File: tb/thread_line_watch_test.sv
module thread_line_watch_test;
   localparam int N  = 4;
   localparam int TW = 3;
   localparam int AW = 32;
   localparam int LB = 64;
   localparam logic [AW-1:0] MASK = ~(AW'(LB - 1));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_valid = 0, mwait_valid = 0, snoop_valid = 0, store_valid = 0;
   logic [TW-1:0] arm_tid = 0, mwait_tid = 0, store_tid = 0;
   logic [AW-1:0] arm_vaddr = 0, mwait_paddr = 0, snoop_addr = 0, store_addr = 0;
   logic          mwait_sleep, core_wake;
   logic [N-1:0]  thr_armed, thr_waiting, thr_woken;
   logic [N*AW-1:0] mon_vaddr, mon_line;

   always #4 clk = ~clk;

   thread_line_watch #(.THREADS(N), .TID_W(TW), .ADDR_W(AW), .LINE_BYTES(LB)) uut (
      .clk(clk), .rst_n(rst_n),
      .arm_valid(arm_valid), .arm_tid(arm_tid), .arm_vaddr(arm_vaddr),
      .mwait_valid(mwait_valid), .mwait_tid(mwait_tid), .mwait_paddr(mwait_paddr),
      .mwait_sleep(mwait_sleep),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .store_valid(store_valid), .store_tid(store_tid), .store_addr(store_addr),
      .thr_armed(thr_armed), .thr_waiting(thr_waiting), .thr_woken(thr_woken),
      .mon_vaddr(mon_vaddr), .mon_line(mon_line), .core_wake(core_wake));

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic          m_arm[N], m_wait[N], m_flag[N];
   logic [AW-1:0] m_va[N], m_ln[N];
   logic          m_core = 0;

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
      return a & MASK;
   endfunction

   task automatic check_state();
      for (int t = 0; t < N; t++) begin
         check($sformatf("R2/R5 armed t%0d", t), 64'(thr_armed[t]), 64'(m_arm[t]));
         check($sformatf("R3/R5 waiting t%0d", t), 64'(thr_waiting[t]), 64'(m_wait[t]));
         check($sformatf("R4/R7 pending t%0d", t), 64'(thr_woken[t]), 64'(m_flag[t]));
         check($sformatf("R2 vaddr t%0d", t), 64'(mon_vaddr[t*AW +: AW]), 64'(m_va[t]));
         check($sformatf("R2/R3 line t%0d", t), 64'(mon_line[t*AW +: AW]), 64'(m_ln[t]));
      end
      check("R5/R6 core_wake", 64'(core_wake), 64'(m_core));
   endtask

   task automatic step(input logic av, input logic [TW-1:0] at, input logic [AW-1:0] aa,
                       input logic wv, input logic [TW-1:0] wt, input logic [AW-1:0] wa,
                       input logic sv, input logic [AW-1:0] sa,
                       input logic lv, input logic [TW-1:0] lt, input logic [AW-1:0] la);
      logic a, w, f, any, exp_sleep;
      logic [AW-1:0] v, l;
      logic hit[N];
      @(negedge clk);
      check_state();
      arm_valid = av; arm_tid = at; arm_vaddr = aa;
      mwait_valid = wv; mwait_tid = wt; mwait_paddr = wa;
      snoop_valid = sv; snoop_addr = sa;
      store_valid = lv; store_tid = lt; store_addr = la;
      #1;
      exp_sleep = wv && (int'(wt) < N) && !m_flag[int'(wt) % N];
      check("R3/R4/R8/R9 sleep answer", 64'(mwait_sleep), 64'(exp_sleep));
      any = 1'b0;
      for (int t = 0; t < N; t++) begin
         a = m_arm[t]; w = m_wait[t]; f = m_flag[t]; v = m_va[t]; l = m_ln[t];
         if (av && int'(at) == t) begin a = 1; v = aa; l = '0; end
         if (wv && int'(wt) == t) begin
            if (!f) begin l = line_of(wa); w = 1; end
            else f = 0;
         end
         hit[t] = a && w && ((sv && l == line_of(sa)) ||
                             (lv && int'(lt) < N && int'(lt) != t && l == line_of(la)));
         any = any | hit[t];
         m_arm[t] = a && !hit[t]; m_wait[t] = w && !hit[t];
         m_flag[t] = f; m_va[t] = v; m_ln[t] = l;
      end
      for (int t = 0; t < N; t++) m_flag[t] = m_flag[t] | any;
      m_core = any;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20251));
      for (int t = 0; t < N; t++) begin
         m_arm[t] = 0; m_wait[t] = 0; m_flag[t] = 0; m_va[t] = 0; m_ln[t] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 reset flags", 64'({thr_armed, thr_waiting, thr_woken, core_wake}), 64'(0));
      check("R1 reset addrs", 64'(|{mon_vaddr, mon_line}), 64'(0));

      // R2/R3: arm and sleep on thread 0
      step(1, 0, 32'h1000_0100, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, 32'h0000_0123, 0, 0, 0, 0, 0);
      // R6: own store must not wake thread 0
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_013F);
      idle();
      check("R6 own store keeps waiting", 64'(thr_waiting[0]), 64'(1));
      check("R6 own store no wake", 64'(core_wake), 64'(0));
      // R6/R7: store from thread 2 wakes thread 0, all flags set
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 32'h0000_0108);
      idle();
      check("R5 pulse after store match", 64'(core_wake), 64'(1));
      check("R7 all flags", 64'(thr_woken), 64'({N{1'b1}}));
      // R4: pending wakeup makes the next wait a no-sleep
      step(0, 0, 0, 1, 0, 32'h0000_0200, 0, 0, 0, 0, 0);
      idle();
      check("R4 flag consumed", 64'(thr_woken[0]), 64'(0));
      check("R4 pulse ends", 64'(core_wake), 64'(0));
      // R8: out-of-range indices
      step(1, 5, 32'hDEAD_0000, 1, 6, 32'h0000_0400, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 32'h0000_0200);
      idle();
      check("R8 bad index no arm", 64'(thr_armed), 64'(0));
      // R9: arm, then wait and matching snoop in the same cycle
      step(1, 0, 32'h0000_0300, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, 32'h0000_0300, 1, 32'h0000_033C, 0, 0, 0);
      idle();
      check("R9 wait then wake", 64'({thr_waiting[0], thr_woken[0], core_wake}), 64'(3'b011));
      // R10: arm and wait to thread 3 together (thread 3 flag pending: consumed)
      step(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0);
      step(1, 3, 32'h0000_0480, 1, 3, 32'h0000_0490, 0, 0, 0, 0, 0);
      idle();
      check("R10 arm then wait", 64'({thr_armed[3], thr_waiting[3]}), 64'(2'b11));
      check("R10 line", 64'(mon_line[3*AW +: AW]), 64'(32'h0000_0480));

      // random traffic over a small line pool
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 100) < 25, TW'($urandom), 32'h0001_0000 + ($urandom % 4) * 64 + $urandom % 64,
              ($urandom % 100) < 30, TW'($urandom), 32'h0001_0000 + ($urandom % 4) * 64 + $urandom % 64,
              ($urandom % 100) < 12, 32'h0001_0000 + ($urandom % 4) * 64 + $urandom % 64,
              ($urandom % 100) < 18, TW'($urandom), 32'h0001_0000 + ($urandom % 4) * 64 + $urandom % 64);
      end
      idle();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule